// File: doc/BRIEF.md
# UART Sleep and Low-Power Controller

This block decides when a UART may stop its core clock and its baud-rate clock to save power, and when it must run again. It watches two enable bits, the empty flags of the transmit FIFO, transmit shift register and receive FIFO, the pending-interrupt flag, the modem inputs and the receive line. When everything is quiet it drops a single clock-enable output. That output drives the clock-gating cells of both the UART clock and the baud clock. The block wakes on receive, transmit or modem activity, and it goes back to sleep by itself once the line is quiet again.

A separate low-power pin overrides everything. While the pin is high, the clock enable is forced low at once, with no clock edge needed, and a host-interface isolate output is forced high. The controller itself runs on a free-running clock that is never gated, so it keeps seeing wake events while the UART clocks are stopped. A third output warns the register file not to accept divisor-latch writes while the clocks are stopped.

The state machine has three states. ST_RUN means clocks running. ST_SLEEP means clocks stopped by the sleep logic. ST_LOWPWR means forced off by the pin. The transitions are:
- ST_RUN to ST_SLEEP on "enter", when all sleep conditions hold.
- ST_SLEEP to ST_RUN on "wake", or when an enable bit is cleared.
- ST_RUN or ST_SLEEP to ST_LOWPWR on "force", when the pin is high.
- ST_LOWPWR to ST_RUN on "release", when the pin is low.

Top module: `uart_doze_ctrl`

## Requirements
- R1: Sleep is entered only while both `enh_en` and `sleep_en` are 1. Clearing `enh_en` while in ST_SLEEP returns the block to ST_RUN on the next edge.
- R2: Sleep is entered only while `txf_empty`, `tsr_empty` and `rxf_empty` are 1, `irq_pend` is 0, and no modem input changed in the current cycle.
- R3: An idle counter advances on each `baud_tick` while `rx_in` is 1. It is cleared whenever `rx_in` is 0. It saturates at 4 × CHAR_BITS. With `rx_ovr` = 0, entry happens on the edge after the counter reaches that limit.
- R4: With `rx_ovr` = 1, the RX level and the idle counter are ignored when deciding on entry.
- R5: `clk_en` is 1 in ST_RUN and 0 in ST_SLEEP. This one signal gates both the UART clock and the baud clock.
- R6: In ST_SLEEP, any of the following moves the block to ST_RUN on the next edge: a falling edge on `rx_in`, a one-cycle `txf_load` pulse, or a change of any `modem_in` bit.
- R7: After a wake, the block re-enters ST_SLEEP as soon as the entry conditions hold again. Clearing `sleep_en` while in ST_SLEEP returns it to ST_RUN.
- R8: While `lowpwr_pin` is 1, `clk_en` is 0 and `iso_en` is 1 in the same cycle, with no edge needed. The pin has priority over all wake events. When the pin falls, the block returns to ST_RUN on the next edge.
- R9: `div_wr_block` is 1 whenever the clocks are stopped (ST_SLEEP, ST_LOWPWR, or the pin high) and 0 in ST_RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running, never-gated clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lowpwr_pin | input | 1 | Forces low-power mode while high |
| enh_en | input | 1 | Enhanced-functions enable bit |
| sleep_en | input | 1 | Sleep enable bit |
| rx_ovr | input | 1 | 1 = ignore RX idle time for entry |
| txf_empty | input | 1 | Transmit FIFO empty |
| tsr_empty | input | 1 | Transmit shift register empty |
| rxf_empty | input | 1 | Receive FIFO empty |
| irq_pend | input | 1 | An interrupt is pending |
| txf_load | input | 1 | One-cycle pulse when the TX FIFO is written |
| rx_in | input | 1 | Serial receive line, idle high |
| modem_in | input | MODEM_W | Modem status inputs |
| baud_tick | input | 1 | One pulse per bit time |
| clk_en | output | 1 | Enable for the UART and baud clock gates |
| iso_en | output | 1 | Isolate the host interface |
| div_wr_block | output | 1 | Divisor-latch writes must be refused |

## Verification
The case that is hardest to reach from the ports is the exact cycle of sleep entry after a long idle stretch, especially right after a receive-triggered wake, when the counter must restart from zero. The bench holds `baud_tick` high every cycle, so the count runs at a known rate. It then checks that `clk_en` is still 1 one edge before the limit and 0 exactly one edge after it. The same test runs again after RX has been held low. The low-power priority case is reached by raising the pin while asleep and then producing an RX falling edge under it.

// File: rtl/uart_doze_pkg.sv
package uart_doze_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SLEEP  = 2'd1,
        ST_LOWPWR = 2'd2
    } doze_state_t;
endpackage

// File: rtl/doze_idle_timer.sv
module doze_idle_timer #(
    parameter int CHAR_BITS  = 10,
    parameter int IDLE_CHARS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    input  logic baud_tick,
    output logic idle_done
);
    localparam int LIMIT = IDLE_CHARS * CHAR_BITS;
    localparam int CW    = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt <= '0;
        else if (!rx_in)                     cnt <= '0;
        else if (baud_tick && cnt != LIM_V)  cnt <= cnt + 1'b1;
    end

    assign idle_done = (cnt == LIM_V);

    // R3: a low RX level restarts the count
    p_rx_low_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_in |=> cnt == '0);
    // R3: the count never passes the limit
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIM_V);
endmodule

// File: rtl/doze_wake_detect.sv
module doze_wake_detect #(
    parameter int MODEM_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_in,
    input  logic               txf_load,
    input  logic [MODEM_W-1:0] modem_in,
    output logic               mdm_chg,
    output logic               wake
);
    logic               rx_q;
    logic [MODEM_W-1:0] mdm_q;
    logic [MODEM_W-1:0] bit_chg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q  <= 1'b1;
            mdm_q <= '0;
        end else begin
            rx_q  <= rx_in;
            mdm_q <= modem_in;
        end
    end

    for (genvar i = 0; i < MODEM_W; i++) begin : g_mdm
        assign bit_chg[i] = modem_in[i] ^ mdm_q[i];
    end

    assign mdm_chg = |bit_chg;
    assign wake    = (rx_q & ~rx_in) | txf_load | mdm_chg;

    // R6: a falling RX edge always raises wake
    p_rx_fall_wakes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rx_in) && !rx_in) |-> wake);
endmodule

// File: rtl/uart_doze_ctrl.sv
module uart_doze_ctrl
    import uart_doze_pkg::*;
#(
    parameter int CHAR_BITS  = 10,
    parameter int IDLE_CHARS = 4,
    parameter int MODEM_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lowpwr_pin,
    input  logic               enh_en,
    input  logic               sleep_en,
    input  logic               rx_ovr,
    input  logic               txf_empty,
    input  logic               tsr_empty,
    input  logic               rxf_empty,
    input  logic               irq_pend,
    input  logic               txf_load,
    input  logic               rx_in,
    input  logic [MODEM_W-1:0] modem_in,
    input  logic               baud_tick,
    output logic               clk_en,
    output logic               iso_en,
    output logic               div_wr_block
);
    doze_state_t state, nxt;
    logic idle_done, mdm_chg, wake;
    logic allowed, quiet, enter_ok;

    doze_idle_timer #(.CHAR_BITS(CHAR_BITS), .IDLE_CHARS(IDLE_CHARS)) u_idle (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .baud_tick(baud_tick),
        .idle_done(idle_done)
    );

    doze_wake_detect #(.MODEM_W(MODEM_W)) u_wake (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .txf_load(txf_load),
        .modem_in(modem_in), .mdm_chg(mdm_chg), .wake(wake)
    );

    assign allowed  = enh_en & sleep_en;
    assign quiet    = txf_empty & tsr_empty & rxf_empty & ~irq_pend & ~mdm_chg;
    assign enter_ok = allowed & quiet & (rx_ovr | idle_done) & ~wake;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:    if (lowpwr_pin) nxt = ST_LOWPWR;
                       else if (enter_ok) nxt = ST_SLEEP;
            ST_SLEEP:  if (lowpwr_pin) nxt = ST_LOWPWR;
                       else if (wake || !allowed) nxt = ST_RUN;
            ST_LOWPWR: if (!lowpwr_pin) nxt = ST_RUN;
            default:   nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    always_comb begin
        clk_en       = (state == ST_RUN) && !lowpwr_pin;
        iso_en       = (state == ST_LOWPWR) || lowpwr_pin;
        div_wr_block = !clk_en;
    end

    // R1: entering sleep needs both enable bits in the prior cycle
    p_enter_enabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !lowpwr_pin) ##1 (state == ST_SLEEP) |-> $past(enh_en && sleep_en));
    // R6: a wake event in sleep, with the pin low, leads to run
    p_wake_runs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && wake && !lowpwr_pin) |=> state == ST_RUN);
    // R8: the pin stops clocks and isolates at once
    p_lowpwr_now_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lowpwr_pin |-> (!clk_en && iso_en));
    // R8: the pin held high keeps the block in low-power
    p_lowpwr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lowpwr_pin |=> state == ST_LOWPWR);
    // R9: divisor writes are blocked while asleep
    p_div_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP) |-> div_wr_block);
endmodule

// File: tb/uart_doze_ctrl_tb_top.sv
module uart_doze_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lowpwr_pin = 0, enh_en = 1, sleep_en = 1, rx_ovr = 0;
    logic txf_empty = 1, tsr_empty = 1, rxf_empty = 1, irq_pend = 0;
    logic txf_load = 0, rx_in = 1, baud_tick = 1;
    logic [3:0] modem_in = 4'b0000;
    logic clk_en, iso_en, div_wr_block;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always #4 clk = ~clk;

    uart_doze_ctrl #(.CHAR_BITS(10), .IDLE_CHARS(4), .MODEM_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .lowpwr_pin(lowpwr_pin), .enh_en(enh_en),
        .sleep_en(sleep_en), .rx_ovr(rx_ovr), .txf_empty(txf_empty),
        .tsr_empty(tsr_empty), .rxf_empty(rxf_empty), .irq_pend(irq_pend),
        .txf_load(txf_load), .rx_in(rx_in), .modem_in(modem_in),
        .baud_tick(baud_tick), .clk_en(clk_en), .iso_en(iso_en),
        .div_wr_block(div_wr_block)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic exp_ce, input logic exp_iso,
                       input logic exp_blk);
        vectors++;
        if (clk_en !== exp_ce || iso_en !== exp_iso || div_wr_block !== exp_blk) begin
            miscompares++;
            $display("FAIL %s: got ce=%b iso=%b blk=%b, expected ce=%b iso=%b blk=%b",
                     req, clk_en, iso_en, div_wr_block, exp_ce, exp_iso, exp_blk);
        end
    endtask

    task automatic t_reset;
        tick(1);
        rst_n = 1'b1;
        #1;
        chk("R5 reset", 1, 0, 0);
    endtask

    task automatic t_idle_entry;
        tick(40);
        chk("R3 one edge before limit", 1, 0, 0);
        tick(1);
        chk("R3 R5 enter after limit", 0, 0, 1);
        chk("R9 block in sleep", 0, 0, 1);
    endtask

    task automatic t_rx_wake;
        rx_in = 0;
        tick(1);
        chk("R6 rx fall wake", 1, 0, 0);
        tick(5);
        chk("R3 rx low keeps awake", 1, 0, 0);
        rx_in = 1;
        tick(40);
        chk("R3 restart count", 1, 0, 0);
        tick(1);
        chk("R7 auto re-entry", 0, 0, 1);
    endtask

    task automatic t_txload_wake;
        txf_load = 1;
        tick(1);
        chk("R6 tx load wake", 1, 0, 0);
        txf_load = 0;
        tick(1);
        chk("R7 re-sleep after tx wake", 0, 0, 1);
    endtask

    task automatic t_modem_wake;
        modem_in = 4'b0010;
        tick(1);
        chk("R6 modem change wake", 1, 0, 0);
        tick(1);
        chk("R7 re-sleep after modem wake", 0, 0, 1);
    endtask

    task automatic t_conditions;
        sleep_en = 0;
        tick(1);
        chk("R7 sleep_en cleared exits", 1, 0, 0);
        sleep_en = 1;
        irq_pend = 1;
        tick(3);
        chk("R2 irq pending blocks", 1, 0, 0);
        irq_pend = 0;
        tsr_empty = 0;
        tick(3);
        chk("R2 shift reg busy blocks", 1, 0, 0);
        tsr_empty = 1;
        rxf_empty = 0;
        tick(3);
        chk("R2 rx fifo data blocks", 1, 0, 0);
        rxf_empty = 1;
        tick(1);
        chk("R2 all clear enters", 0, 0, 1);
        enh_en = 0;
        tick(1);
        chk("R1 enh cleared exits", 1, 0, 0);
        tick(3);
        chk("R1 enh off blocks", 1, 0, 0);
        enh_en = 1;
        tick(1);
        chk("R1 enh on enters", 0, 0, 1);
    endtask

    task automatic t_override;
        sleep_en = 0;
        tick(1);
        chk("R7 exit before override", 1, 0, 0);
        rx_in = 0;
        rx_ovr = 1;
        sleep_en = 1;
        tick(1);
        chk("R4 fall edge cycle stays awake", 1, 0, 0);
        tick(1);
        chk("R4 override enters with rx low", 0, 0, 1);
        rx_ovr = 0;
        tick(1);
        rx_in = 1;
        tick(2);
        chk("R4 stays asleep", 0, 0, 1);
    endtask

    task automatic t_lowpwr;
        lowpwr_pin = 1;
        #1;
        chk("R8 immediate force", 0, 1, 1);
        rx_in = 0;
        tick(2);
        chk("R8 priority over rx wake", 0, 1, 1);
        rx_in = 1;
        lowpwr_pin = 0;
        #1;
        chk("R8 held until edge", 0, 1, 1);
        tick(1);
        chk("R8 release to run", 1, 0, 0);
    endtask

    initial begin
        t_reset();
        t_idle_entry();
        t_rx_wake();
        t_txload_wake();
        t_modem_wake();
        t_conditions();
        t_override();
        t_lowpwr();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule